// File: doc/BRIEF.md
# BCD Time-of-Day Calendar with Snapshot Registers

The block keeps the time of day and the calendar date as packed BCD bytes: seconds, minutes, hours (24-hour), day of week, day of month, month and two-digit year. A one-cycle `tick_i` pulse, produced once per second elsewhere, advances an internal counter set. Month length is handled, and February gets a 29th day in leap years. The day of week counts 1 to 7 and steps at midnight.

Software sees a second set of registers, the user set. After each internal advance, the internal values are copied into the user set on the following cycle, but only while the transfer-enable bit is set. Clearing the bit freezes the user set, so software can read a consistent snapshot while the internal counters keep running. After the bit is set again, copies stay blocked for a fixed number of clock cycles. A software write to a time field loads the internal counter and the user copy together.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes count 00..59 and hours count 00..23, all in BCD. Each field wraps to 00 and carries into the next field.
- R2: The day of month wraps to 01 after 30 in months 04, 06, 09 and 11. It wraps after 31 in the other months, except February, which wraps after 28 (or 29, see R3). A wrap increments the month.
- R3: A year whose BCD value is divisible by 4, 00 included, is a leap year, and February then reaches 29 before wrapping.
- R4: The day of week (address 3) increments when 23:59:59 rolls over, and wraps from 7 to 1.
- R5: Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R6: While transfer enable is 0, the user set holds its values, and the internal set keeps advancing on every tick.
- R7: With transfer enable at 1 and the guard expired, the user set takes the internal values one clock after each accepted tick.
- R8: After transfer enable goes from 0 to 1, no copy occurs until GUARD_CYC clock cycles have passed. A copy that falls in this window is dropped.
- R9: A write to address 0..6 loads both the internal field and the user field in the same cycle, whatever transfer enable is. A tick that arrives in the same cycle is ignored. A write to address 7 does not block a tick.
- R10: The register map is address 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, and 7 control, where bit 0 is transfer enable. Reads are combinational. After reset the registers hold 00:00:00, day of week 1, date 01, month 01, year 00, and transfer enable 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed user register |

## Verification
The hardest case to reach is a tick that arrives inside the guard window right after transfer enable is set again. A copy there must be dropped, and a later copy must show every advance that happened while the user set was frozen. The bench freezes the user set and ticks several times. It then sets transfer enable and ticks at once, and checks that the stale snapshot is still visible. Finally it waits out the guard, ticks again and expects the full accumulated time. Calendar rollovers that would take years of ticks are reached by writing 23:59:59 on the last day of random months and years, and then ticking.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sec;
  } cal_t;

  localparam logic [2:0] A_SEC  = 3'd0;
  localparam logic [2:0] A_MIN  = 3'd1;
  localparam logic [2:0] A_HR   = 3'd2;
  localparam logic [2:0] A_DOW  = 3'd3;
  localparam logic [2:0] A_DATE = 3'd4;
  localparam logic [2:0] A_MON  = 3'd5;
  localparam logic [2:0] A_YR   = 3'd6;
  localparam logic [2:0] A_CTRL = 3'd7;

  localparam cal_t CAL_RST = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                               hr: 8'h00, mn: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [7:0] b;
    b = {4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]};
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02: return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic cal_t put_field(input cal_t c, input logic [2:0] a, input logic [7:0] d);
    cal_t r;
    r = c;
    case (a)
      A_SEC:  r.sec  = d;
      A_MIN:  r.mn   = d;
      A_HR:   r.hr   = d;
      A_DOW:  r.dow  = d;
      A_DATE: r.date = d;
      A_MON:  r.mon  = d;
      A_YR:   r.yr   = d;
      default: r = c;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] get_field(input cal_t c, input logic [2:0] a);
    case (a)
      A_SEC:  return c.sec;
      A_MIN:  return c.mn;
      A_HR:   return c.hr;
      A_DOW:  return c.dow;
      A_DATE: return c.date;
      A_MON:  return c.mon;
      A_YR:   return c.yr;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
#(
  parameter logic [7:0] DOW_LAST = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_i,
  input  logic [2:0] waddr_i,
  input  logic [7:0] wdata_i,
  output cal_t       cur_o
);
  cal_t cur_q, nxt;
  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    nxt   = cur_q;
    c_min = (cur_q.sec == 8'h59);
    c_hr  = c_min && (cur_q.mn == 8'h59);
    c_day = c_hr && (cur_q.hr == 8'h23);
    c_mon = c_day && (cur_q.date == last_day(cur_q.mon, cur_q.yr));
    c_yr  = c_mon && (cur_q.mon == 8'h12);
    nxt.sec = c_min ? 8'h00 : bcd_inc(cur_q.sec);
    if (c_min) nxt.mn = c_hr ? 8'h00 : bcd_inc(cur_q.mn);
    if (c_hr)  nxt.hr = c_day ? 8'h00 : bcd_inc(cur_q.hr);
    if (c_day) begin
      nxt.dow  = (cur_q.dow == DOW_LAST) ? 8'h01 : cur_q.dow + 8'd1;
      nxt.date = c_mon ? 8'h01 : bcd_inc(cur_q.date);
    end
    if (c_mon) nxt.mon = c_yr ? 8'h01 : bcd_inc(cur_q.mon);
    if (c_yr)  nxt.yr  = (cur_q.yr == 8'h99) ? 8'h00 : bcd_inc(cur_q.yr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cur_q <= CAL_RST;
    else if (wr_i)  cur_q <= put_field(cur_q, waddr_i, wdata_i);
    else if (adv_i) cur_q <= nxt;
  end

  assign cur_o = cur_q;

  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !wr_i) |=> $stable(cur_q));

  // R4
  dow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_i && cur_q.hr == 8'h23 && cur_q.mn == 8'h59 && cur_q.sec == 8'h59
     && cur_q.dow == DOW_LAST) |=> (cur_q.dow == 8'h01));

  // R1
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_i && cur_q.sec == 8'h59) |=> (cur_q.sec == 8'h00));
endmodule

// File: rtl/xfer_gate.sv
module xfer_gate #(
  parameter int GUARD_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic ctl_wr_i,
  input  logic te_d_i,
  output logic te_o,
  output logic copy_o
);
  localparam int GW = $clog2(GUARD_CYC + 1);

  logic          te_q, pend_q;
  logic [GW-1:0] guard_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      te_q    <= 1'b1;
      pend_q  <= 1'b0;
      guard_q <= '0;
    end else begin
      pend_q <= adv_i;
      if (ctl_wr_i) te_q <= te_d_i;
      if (ctl_wr_i && te_d_i && !te_q) guard_q <= GW'(GUARD_CYC);
      else if (guard_q != '0)          guard_q <= guard_q - 1'b1;
    end
  end

  assign te_o   = te_q;
  assign copy_o = pend_q && te_q && (guard_q == '0);

  // R7
  copy_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_o |-> $past(adv_i));

  // R8
  guard_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && te_d_i && !te_q) |=> (!copy_o && guard_q == GW'(GUARD_CYC)));
endmodule

// File: rtl/shadow_regs.sv
module shadow_regs
  import cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       copy_i,
  input  cal_t       cal_i,
  input  logic       wr_i,
  input  logic [2:0] waddr_i,
  input  logic [7:0] wdata_i,
  output cal_t       user_o
);
  cal_t user_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               user_q <= CAL_RST;
    else if (wr_i && copy_i)   user_q <= put_field(cal_i, waddr_i, wdata_i);
    else if (wr_i)             user_q <= put_field(user_q, waddr_i, wdata_i);
    else if (copy_i)           user_q <= cal_i;
  end

  assign user_o = user_q;

  // R6
  user_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!copy_i && !wr_i) |=> $stable(user_q));

  // R9
  user_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (get_field(user_q, $past(waddr_i)) == $past(wdata_i)));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int         GUARD_CYC = 12,
  parameter logic [7:0] DOW_LAST  = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  cal_t cur, usr;
  logic wr_time, wr_ctl, adv, te, copy;

  assign wr_time = wr_en_i && (addr_i != A_CTRL);
  assign wr_ctl  = wr_en_i && (addr_i == A_CTRL);
  assign adv     = tick_i && !wr_time;

  cal_counter #(.DOW_LAST(DOW_LAST)) u_cnt (
    .clk_i, .rst_ni, .adv_i(adv), .wr_i(wr_time),
    .waddr_i(addr_i), .wdata_i, .cur_o(cur)
  );

  xfer_gate #(.GUARD_CYC(GUARD_CYC)) u_xfer (
    .clk_i, .rst_ni, .adv_i(adv), .ctl_wr_i(wr_ctl),
    .te_d_i(wdata_i[0]), .te_o(te), .copy_o(copy)
  );

  shadow_regs u_shadow (
    .clk_i, .rst_ni, .copy_i(copy), .cal_i(cur), .wr_i(wr_time),
    .waddr_i(addr_i), .wdata_i, .user_o(usr)
  );

  assign rdata_o = (addr_i == A_CTRL) ? {7'd0, te} : get_field(usr, addr_i);

  // R9
  wr_blocks_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_time && tick_i) |=> !copy);
endmodule

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  localparam int CLK_PERIOD = 10;
  localparam int GUARD = 12;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;

  int n_chk = 0, n_bad = 0;
  int m_f[7];   // model internal: sec,min,hr,dow,date,mon,yr (binary)
  int u_f[7];   // expected user set (binary)

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar #(.GUARD_CYC(GUARD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_adv();
    m_f[0]++;
    if (m_f[0] == 60) begin
      m_f[0] = 0; m_f[1]++;
      if (m_f[1] == 60) begin
        m_f[1] = 0; m_f[2]++;
        if (m_f[2] == 24) begin
          m_f[2] = 0;
          m_f[3] = (m_f[3] == 7) ? 1 : m_f[3] + 1;
          m_f[4]++;
          if (m_f[4] > dim(m_f[5], m_f[6])) begin
            m_f[4] = 1; m_f[5]++;
            if (m_f[5] == 13) begin m_f[5] = 1; m_f[6] = (m_f[6] + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp_v);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), d);
      check($sformatf("%s field%0d", req, i), d, to_bcd(u_f[i]));
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input int v);
    @(negedge clk); wr = 1'b1; addr = a; wdata = (a == 3'd7) ? 8'(v) : to_bcd(v);
    @(negedge clk); wr = 1'b0;
    if (a != 3'd7) begin m_f[a] = v; u_f[a] = v; end
  endtask

  // one tick, then one more cycle for the copy
  task automatic do_tick(input bit copy_exp);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    model_adv();
    if (copy_exp) u_f = m_f;
  endtask

  task automatic set_time(input int y, input int mo, input int dt, input int h,
                          input int mi, input int s);
    wr_reg(3'd6, y); wr_reg(3'd5, mo); wr_reg(3'd4, dt);
    wr_reg(3'd2, h); wr_reg(3'd1, mi); wr_reg(3'd0, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    m_f = '{0, 0, 0, 1, 1, 1, 0};
    u_f = m_f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check_all("R10 reset");
    rd(3'd7, d); check("R10 ctrl reset", d, 8'h01);

    // R1 ripple 23:59:59 -> 00:00:00, R4 dow 7 -> 1
    wr_reg(3'd3, 7);
    set_time(22, 6, 14, 23, 59, 59);
    check_all("R9 load");
    do_tick(1'b1);
    check_all("R1 R4 midnight");
    rd(3'd3, d); check("R4 dow wrap", d, 8'h01);

    // R2 30-day month, R3 leap / non-leap Feb, R5 year wrap
    set_time(23, 4, 30, 23, 59, 59); do_tick(1'b1); check_all("R2 april end");
    set_time(23, 2, 28, 23, 59, 59); do_tick(1'b1); check_all("R2 feb nonleap");
    set_time(24, 2, 28, 23, 59, 59); do_tick(1'b1); check_all("R3 feb 29 leap");
    rd(3'd4, d); check("R3 leap date", d, 8'h29);
    set_time(24, 2, 29, 23, 59, 59); do_tick(1'b1); check_all("R3 leap end");
    set_time(0, 2, 28, 23, 59, 59); do_tick(1'b1); check_all("R3 year 00 leap");
    set_time(99, 12, 31, 23, 59, 59); do_tick(1'b1); check_all("R5 year wrap");

    // R9 write with same-cycle tick: tick ignored
    wr_reg(3'd0, 10);
    @(negedge clk); wr = 1'b1; addr = 3'd0; wdata = to_bcd(30); tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    m_f[0] = 30; u_f[0] = 30;
    @(negedge clk);
    check_all("R9 write beats tick");

    // R6 freeze, R8 guard, R7 resume
    wr_reg(3'd7, 0);
    for (int i = 0; i < 5; i++) do_tick(1'b0);
    check_all("R6 frozen");
    rd(3'd7, d); check("R6 ctrl te=0", d, 8'h00);
    wr_reg(3'd1, 42);
    check_all("R9 write while frozen");
    wr_reg(3'd7, 1);
    do_tick(1'b0);
    check_all("R8 guard blocks copy");
    repeat (GUARD + 2) @(negedge clk);
    do_tick(1'b1);
    check_all("R7 copy after guard");

    // R9 control write does not block tick
    @(negedge clk); wr = 1'b1; addr = 3'd7; wdata = 8'h01; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    @(negedge clk);
    model_adv(); u_f = m_f;
    check_all("R9 ctrl write with tick");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: begin
          int a;
          a = int'($urandom % 4);
          case (a)
            0: wr_reg(3'd0, int'($urandom % 60));
            1: wr_reg(3'd1, int'($urandom % 60));
            2: wr_reg(3'd2, int'($urandom % 24));
            default: wr_reg(3'd3, 1 + int'($urandom % 7));
          endcase
        end
        1: begin
          int y, mo;
          y = int'($urandom % 100); mo = 1 + int'($urandom % 12);
          set_time(y, mo, dim(mo, y), 23, 59, 58 + int'($urandom % 2));
        end
        default: begin
          int n;
          n = 1 + int'($urandom % 4);
          for (int k = 0; k < n; k++) do_tick(1'b1);
        end
      endcase
      check_all("R7 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule